// File: doc/BRIEF.md
# Secure Context Save Sequencer

This block drives the save of a crypto engine's private state before a low-power entry. Once started, it walks every piece of saveable state in a fixed nested order and, for each 16-byte block, presents one request (source class, slot or key index, word-quad index) to a downstream encrypt-and-write datapath over a valid/ready handshake. The datapath, the random source, the key storage and the memory writes sit outside the block. Here they appear only as the party that raises ready.

A configuration input selects between two image layouts. The short layout holds 132 blocks: random data, sticky words, the symmetric key table and the RSA key table, closed by a known-pattern block. The long layout holds 645 blocks, because a public-key accelerator region of one sticky block and 512 key blocks is placed in front of the known pattern. A running block counter is visible at all times and clears only on reset. A save is refused if this counter is already non-zero, and at the end the counter is compared against the exact image size. Before the first request, the block waits for the engine to be idle and for any leftover operation-done interrupt to be cleared. A stall watchdog bounds the wait for each block.

Top module: `ctx_save_seq`

## Requirements
- R1: After reset, req_valid, done, err and irq_clr are 0 and blk_count is 0.
- R2: After an accepted start, no request is issued while eng_idle is 0 or irq_pend is 1. irq_clr is 1 exactly while waiting with irq_pend high. The first request appears on the second rising edge after start when eng_idle=1 and irq_pend=0.
- R3: Source class codes on req_src are 0 random data, 1 sticky words, 2 symmetric key table, 3 RSA keys, 4 public-key sticky, 5 public-key keys, 6 known pattern. The short image is one class-0 block, two class-1 blocks with word-quad 0 then 1, the class-2 and class-3 regions, then one class-6 block: 132 blocks in total.
- R4: The symmetric key table runs over slots 0 to 15 on req_idx. Each slot gives four blocks with word-quad 0 and 1 for the key, then 2 for the original IV, then 3 for the updated IV.
- R5: The RSA region runs req_idx 0 (slot 0 exponent), 1 (slot 0 modulus), 2 (slot 1 exponent), 3 (slot 1 modulus). Each index gives 16 blocks with word-quad 0 to 15.
- R6: With big_sel=1 at start, one class-4 block is inserted after the RSA region, followed by 512 class-5 blocks with flat index f=slot*128+quad running 0 to 511. req_qlo carries f[3:0] and req_qhi carries f[8:4]. For every other class req_qhi is 0. The total is 645 blocks.
- R7: Once raised, req_valid and the request fields stay unchanged until req_ready is sampled high, unless the watchdog aborts.
- R8: blk_count rises by exactly one on each accepted request, is otherwise unchanged, and only reset clears it.
- R9: A start that arrives while blk_count is non-zero is rejected. On the edge that samples it, done and err are set, no request follows and blk_count is unchanged.
- R10: done rises one cycle after the final accepted request. err is set then only if blk_count differs from the image size (132 or 645).
- R11: If req_valid is held without req_ready for WDOG_LIM consecutive rising edges, that last edge sets done and err and drops req_valid. blk_count is kept.
- R12: done and err stay set until the next start is taken in idle, which clears them. A start pulse while a save is running has no effect on the request stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Save trigger, sampled in idle |
| big_sel | input | 1 | 1 selects the long layout with the public-key region, latched at start |
| eng_idle | input | 1 | Engine status idle |
| irq_pend | input | 1 | Operation-done interrupt still pending |
| req_ready | input | 1 | Datapath accepts the current block |
| req_valid | output | 1 | Block request present |
| req_src | output | 3 | Source class code |
| req_idx | output | 4 | Slot or key index |
| req_qlo | output | 4 | Word-quad index, low field |
| req_qhi | output | 5 | Word-quad index, high field (public-key keys only) |
| irq_clr | output | 1 | Clear request for the pending interrupt |
| blk_count | output | 10 | Accepted block counter |
| done | output | 1 | Save finished or aborted (sticky) |
| err | output | 1 | Save rejected, aborted or wrong count (sticky) |

## Verification
Each result has a fixed latency. A request is visible two edges after a start taken with the engine ready. Rejection flags appear on the edge that samples start. done follows the last handshake by one edge, and the abort lands on the WDOG_LIM-th stalled edge. The bench drives inputs and samples outputs on the falling edge. It therefore checks the CHECK cycle, where done is still low, separately from the edge that raises done, and it checks the stall window one edge before and one edge at the abort. Request fields are compared against an arithmetic model of the image at the falling edge where ready is driven high, so the value compared is the one the datapath accepts.

// File: rtl/ctxs_pkg.sv
package ctxs_pkg;

  typedef enum logic [2:0] {
    SEC_RAND   = 3'd0,
    SEC_STICKY = 3'd1,
    SEC_AES    = 3'd2,
    SEC_RSA    = 3'd3,
    SEC_PKST   = 3'd4,
    SEC_PKKEY  = 3'd5,
    SEC_PAT    = 3'd6
  } sec_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PREP  = 2'd1,
    ST_RUN   = 2'd2,
    ST_CHECK = 2'd3
  } fsm_e;

  function automatic int unsigned img_blocks(input int unsigned sticky_q,
                                             input int unsigned aes_slots,
                                             input int unsigned rsa_slots,
                                             input int unsigned rsa_quads,
                                             input int unsigned pk_flat,
                                             input bit          big);
    int unsigned n;
    n = 1 + sticky_q + 4 * aes_slots + 2 * rsa_slots * rsa_quads + 1;
    if (big) n = n + 1 + pk_flat;
    return n;
  endfunction

endpackage

// File: rtl/ctxs_walker.sv
module ctxs_walker
  import ctxs_pkg::*;
#(
  parameter int STICKY_Q  = 2,
  parameter int AES_SLOTS = 16,
  parameter int RSA_SLOTS = 2,
  parameter int RSA_QUADS = 16,
  parameter int PK_FLAT   = 512,
  parameter int IDX_W     = 4,
  parameter int QF_W      = 9
) (
  input  sec_e             cur_sec,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [QF_W-1:0]  cur_quad,
  input  logic             big,
  output sec_e             nxt_sec,
  output logic [IDX_W-1:0] nxt_idx,
  output logic [QF_W-1:0]  nxt_quad,
  output logic             is_last
);

  localparam logic [QF_W-1:0]  STK_END  = QF_W'(STICKY_Q - 1);
  localparam logic [QF_W-1:0]  AES_END  = QF_W'(3);
  localparam logic [QF_W-1:0]  RSA_QEND = QF_W'(RSA_QUADS - 1);
  localparam logic [QF_W-1:0]  PK_END   = QF_W'(PK_FLAT - 1);
  localparam logic [IDX_W-1:0] AES_LAST = IDX_W'(AES_SLOTS - 1);
  localparam logic [IDX_W-1:0] RSA_LAST = IDX_W'(2 * RSA_SLOTS - 1);

  logic [QF_W-1:0]  quad_inc;
  logic [IDX_W-1:0] idx_inc;

  assign quad_inc = cur_quad + 1'b1;
  assign idx_inc  = cur_idx + 1'b1;

  always_comb begin
    nxt_sec  = cur_sec;
    nxt_idx  = cur_idx;
    nxt_quad = quad_inc;
    is_last  = 1'b0;
    unique case (cur_sec)
      SEC_RAND: begin
        nxt_sec  = SEC_STICKY;
        nxt_idx  = '0;
        nxt_quad = '0;
      end
      SEC_STICKY: begin
        if (cur_quad == STK_END) begin
          nxt_sec  = SEC_AES;
          nxt_idx  = '0;
          nxt_quad = '0;
        end
      end
      SEC_AES: begin
        if (cur_quad == AES_END) begin
          nxt_quad = '0;
          if (cur_idx == AES_LAST) begin
            nxt_sec = SEC_RSA;
            nxt_idx = '0;
          end else begin
            nxt_idx = idx_inc;
          end
        end
      end
      SEC_RSA: begin
        if (cur_quad == RSA_QEND) begin
          nxt_quad = '0;
          if (cur_idx == RSA_LAST) begin
            nxt_sec = big ? SEC_PKST : SEC_PAT;
            nxt_idx = '0;
          end else begin
            nxt_idx = idx_inc;
          end
        end
      end
      SEC_PKST: begin
        nxt_sec  = SEC_PKKEY;
        nxt_idx  = '0;
        nxt_quad = '0;
      end
      SEC_PKKEY: begin
        if (cur_quad == PK_END) begin
          nxt_sec  = SEC_PAT;
          nxt_idx  = '0;
          nxt_quad = '0;
        end
      end
      default: begin
        nxt_quad = cur_quad;
        is_last  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/ctxs_fields.sv
module ctxs_fields
  import ctxs_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int QF_W  = 9,
  parameter int QLO_W = 4,
  localparam int QHI_W = QF_W - QLO_W
) (
  input  sec_e             cur_sec,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [QF_W-1:0]  cur_quad,
  output logic [2:0]       f_src,
  output logic [IDX_W-1:0] f_idx,
  output logic [QLO_W-1:0] f_qlo,
  output logic [QHI_W-1:0] f_qhi
);

  assign f_src = cur_sec;
  assign f_idx = cur_idx;
  assign f_qlo = cur_quad[QLO_W-1:0];

  generate
    if (QHI_W > 0) begin : g_hi
      assign f_qhi = (cur_sec == SEC_PKKEY) ? cur_quad[QF_W-1:QLO_W] : '0;
    end else begin : g_nohi
      assign f_qhi = '0;
    end
  endgenerate

endmodule

// File: rtl/ctxs_wdog.sv
module ctxs_wdog #(
  parameter int WDOG_LIM = 64,
  localparam int WD_W = (WDOG_LIM > 1) ? $clog2(WDOG_LIM) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall,
  output logic expire
);

  localparam logic [WD_W-1:0] WD_END = WD_W'(WDOG_LIM - 1);

  logic [WD_W-1:0] wd_q, wd_d;
  logic            wd_en;

  assign expire = stall && (wd_q == WD_END);

  always_comb begin
    wd_en = 1'b1;
    wd_d  = stall ? (wd_q + 1'b1) : '0;
    if (!stall && wd_q == '0) wd_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_q <= '0;
    else if (wd_en) wd_q <= wd_d;
  end

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
  import ctxs_pkg::*;
#(
  parameter int STICKY_Q  = 2,
  parameter int AES_SLOTS = 16,
  parameter int RSA_SLOTS = 2,
  parameter int RSA_QUADS = 16,
  parameter int PK_SLOTS  = 4,
  parameter int PK_QUADS  = 128,
  parameter int QLO_W     = 4,
  parameter int WDOG_LIM  = 64,
  localparam int IDX_N     = (AES_SLOTS > 2 * RSA_SLOTS) ? AES_SLOTS : 2 * RSA_SLOTS,
  localparam int IDX_W     = (IDX_N > 1) ? $clog2(IDX_N) : 1,
  localparam int PK_FLAT   = PK_SLOTS * PK_QUADS,
  localparam int QF_W      = $clog2(PK_FLAT),
  localparam int QHI_W     = QF_W - QLO_W,
  localparam int BIG_TOTAL = int'(img_blocks(STICKY_Q, AES_SLOTS, RSA_SLOTS, RSA_QUADS, PK_FLAT, 1'b1)),
  localparam int CNT_W     = $clog2(BIG_TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             big_sel,
  input  logic             eng_idle,
  input  logic             irq_pend,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [2:0]       req_src,
  output logic [IDX_W-1:0] req_idx,
  output logic [QLO_W-1:0] req_qlo,
  output logic [QHI_W-1:0] req_qhi,
  output logic             irq_clr,
  output logic [CNT_W-1:0] blk_count,
  output logic             done,
  output logic             err
);

  localparam logic [CNT_W-1:0] SMALL_CNT =
    CNT_W'(img_blocks(STICKY_Q, AES_SLOTS, RSA_SLOTS, RSA_QUADS, PK_FLAT, 1'b0));
  localparam logic [CNT_W-1:0] BIG_CNT = CNT_W'(BIG_TOTAL);

  // reset: asynchronous assert, two-stage synchronous release
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  fsm_e             st_q, st_d;
  sec_e             sec_q, sec_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [QF_W-1:0]  quad_q, quad_d;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, done_d, err_q, err_d, big_q;
  logic             cur_en, big_en, hs, stall, tmo;

  sec_e             w_sec;
  logic [IDX_W-1:0] w_idx;
  logic [QF_W-1:0]  w_quad;
  logic             w_last;

  ctxs_walker #(
    .STICKY_Q (STICKY_Q),
    .AES_SLOTS(AES_SLOTS),
    .RSA_SLOTS(RSA_SLOTS),
    .RSA_QUADS(RSA_QUADS),
    .PK_FLAT  (PK_FLAT),
    .IDX_W    (IDX_W),
    .QF_W     (QF_W)
  ) u_walk (
    .cur_sec (sec_q),
    .cur_idx (idx_q),
    .cur_quad(quad_q),
    .big     (big_q),
    .nxt_sec (w_sec),
    .nxt_idx (w_idx),
    .nxt_quad(w_quad),
    .is_last (w_last)
  );

  ctxs_fields #(
    .IDX_W(IDX_W),
    .QF_W (QF_W),
    .QLO_W(QLO_W)
  ) u_fld (
    .cur_sec (sec_q),
    .cur_idx (idx_q),
    .cur_quad(quad_q),
    .f_src   (req_src),
    .f_idx   (req_idx),
    .f_qlo   (req_qlo),
    .f_qhi   (req_qhi)
  );

  ctxs_wdog #(
    .WDOG_LIM(WDOG_LIM)
  ) u_wd (
    .clk   (clk),
    .rst_n (rs_n),
    .stall (stall),
    .expire(tmo)
  );

  assign req_valid = (st_q == ST_RUN);
  assign hs        = req_valid && req_ready;
  assign stall     = req_valid && !req_ready;
  assign irq_clr   = (st_q == ST_PREP) && irq_pend;
  assign blk_count = cnt_q;
  assign done      = done_q;
  assign err       = err_q;

  always_comb begin
    st_d   = st_q;
    sec_d  = w_sec;
    idx_d  = w_idx;
    quad_d = w_quad;
    done_d = done_q;
    err_d  = err_q;
    cur_en = 1'b0;
    big_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          big_en = 1'b1;
          if (cnt_q != '0) begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            done_d = 1'b0;
            err_d  = 1'b0;
            st_d   = ST_PREP;
            cur_en = 1'b1;
            sec_d  = SEC_RAND;
            idx_d  = '0;
            quad_d = '0;
          end
        end
      end
      ST_PREP: begin
        if (eng_idle && !irq_pend) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (tmo) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          err_d  = 1'b1;
        end else if (hs) begin
          if (w_last) st_d = ST_CHECK;
          else cur_en = 1'b1;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        if (cnt_q != (big_q ? BIG_CNT : SMALL_CNT)) err_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q   <= ST_IDLE;
      sec_q  <= SEC_RAND;
      idx_q  <= '0;
      quad_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      big_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (cur_en) begin
        sec_q  <= sec_d;
        idx_q  <= idx_d;
        quad_q <= quad_d;
      end
      if (hs)     cnt_q <= cnt_q + 1'b1;
      if (big_en) big_q <= big_sel;
    end
  end

endmodule

// File: rtl/ctxs_seq_chk.sv
module ctxs_seq_chk #(
  parameter int IDX_W = 4,
  parameter int QLO_W = 4,
  parameter int QHI_W = 5,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             req_valid,
  input logic [2:0]       req_src,
  input logic [IDX_W-1:0] req_idx,
  input logic [QLO_W-1:0] req_qlo,
  input logic [QHI_W-1:0] req_qhi,
  input logic             irq_clr,
  input logic [CNT_W-1:0] blk_count,
  input logic             done,
  input logic             err
);

  a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid || err));

  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (err || ($stable(req_src) && $stable(req_idx) &&
                                           $stable(req_qlo) && $stable(req_qhi))));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (blk_count == $past(blk_count) + 1'b1));

  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(blk_count));

  a_r2_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> !req_valid);

  a_r6_high_field: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_qhi != '0) |-> (req_src == 3'd5));

  a_r3_src_code: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_src <= 3'd6));

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

endmodule

bind ctx_save_seq ctxs_seq_chk #(
  .IDX_W(IDX_W),
  .QLO_W(QLO_W),
  .QHI_W(QHI_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .req_valid(req_valid),
  .req_src  (req_src),
  .req_idx  (req_idx),
  .req_qlo  (req_qlo),
  .req_qhi  (req_qhi),
  .irq_clr  (irq_clr),
  .blk_count(blk_count),
  .done     (done),
  .err      (err)
);

// File: tb/ctx_save_seq_test.sv
module ctx_save_seq_test;

  localparam int WD    = 64;
  localparam int SMALL = 132;
  localparam int BIG   = 645;

  typedef struct packed {
    logic       big;
    logic [1:0] mode;
    logic [9:0] total;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{big: 1'b0, mode: 2'd0, total: 10'd132},
    '{big: 1'b0, mode: 2'd2, total: 10'd132},
    '{big: 1'b1, mode: 2'd0, total: 10'd645},
    '{big: 1'b1, mode: 2'd1, total: 10'd645}
  };

  logic       clk = 1'b0;
  logic       rst_n, start, big_sel, eng_idle, irq_pend, req_ready;
  logic       req_valid, irq_clr, done, err;
  logic [2:0] req_src;
  logic [3:0] req_idx, req_qlo;
  logic [4:0] req_qhi;
  logic [9:0] blk_count;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ctx_save_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .big_sel(big_sel),
    .eng_idle(eng_idle), .irq_pend(irq_pend), .req_ready(req_ready),
    .req_valid(req_valid), .req_src(req_src), .req_idx(req_idx),
    .req_qlo(req_qlo), .req_qhi(req_qhi), .irq_clr(irq_clr),
    .blk_count(blk_count), .done(done), .err(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent arithmetic model of the image: {src, idx, qlo, qhi}
  function automatic logic [15:0] exp_blk(input int n, input bit big);
    int s = 6, i = 0, q = 0, k;
    logic [8:0] f;
    if (n == 0) s = 0;
    else if (n < 3) begin s = 1; q = n - 1; end
    else if (n < 67) begin k = n - 3; s = 2; i = k / 4; q = k % 4; end
    else if (n < 131) begin k = n - 67; s = 3; i = k / 16; q = k % 16; end
    else if (big && n == 131) s = 4;
    else if (big && n < 644) begin s = 5; q = n - 132; end
    f = q[8:0];
    return {s[2:0], i[3:0], f[3:0], f[8:4]};
  endfunction

  function automatic string tag_of(input int n, input bit big);
    if (n >= 3 && n < 67) return "R4";
    if (n >= 67 && n < 131) return "R5";
    if (big && n >= 131 && n < 644) return "R6";
    return "R3";
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; big_sel = 1'b0;
    eng_idle = 1'b1; irq_pend = 1'b0; req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_seq(input bit big, input int mode, input int total);
    int n = 0, cyc = 0, guard = 0;
    bit rdy;
    start = 1'b1; big_sel = big;
    @(negedge clk);
    start = 1'b0;
    chk("R12 start clears done", int'(done), 0);
    chk("R12 start clears err", int'(err), 0);
    while (n < total && guard < 20000) begin
      start = (n == 10);
      rdy = ((cyc % (mode + 1)) == 0);
      if (req_valid && rdy) begin
        chk(tag_of(n, big), int'({req_src, req_idx, req_qlo, req_qhi}), int'(exp_blk(n, big)));
        n++;
      end
      req_ready = req_valid && rdy;
      cyc++; guard++;
      @(negedge clk);
    end
    start = 1'b0;
    req_ready = 1'b0;
    chk("R10 block total", n, total);
    chk("R10 done one cycle later", int'(done), 0);
    chk("R10 valid after last", int'(req_valid), 0);
    @(negedge clk);
    chk("R10 done", int'(done), 1);
    chk("R10 err", int'(err), 0);
    chk("R8 count", int'(blk_count), total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 valid", int'(req_valid), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 irq_clr", int'(irq_clr), 0);
    chk("R1 count", int'(blk_count), 0);

    // table of layouts and ready patterns
    for (int v = 0; v < 4; v++) begin
      do_reset();
      run_seq(VECS[v].big, int'(VECS[v].mode), int'(VECS[v].total));
    end

    // R9 rejection with non-zero counter
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done", int'(done), 1);
    chk("R9 err", int'(err), 1);
    chk("R9 count kept", int'(blk_count), BIG);
    repeat (5) @(negedge clk);
    chk("R9 no request", int'(req_valid), 0);
    chk("R12 done sticky", int'(done), 1);
    chk("R12 err sticky", int'(err), 1);

    // R2 wait for idle and cleared interrupt
    do_reset();
    eng_idle = 1'b0; irq_pend = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 5; c++) begin
      chk("R2 held while pending", int'(req_valid), 0);
      chk("R2 irq_clr", int'(irq_clr), 1);
      @(negedge clk);
    end
    irq_pend = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R2 held while busy", int'(req_valid), 0);
      chk("R2 irq_clr low", int'(irq_clr), 0);
    end
    eng_idle = 1'b1;
    @(negedge clk);
    chk("R2 first request", int'(req_valid), 1);
    chk("R3 first class", int'(req_src), 0);

    // R11 watchdog on a stalled block
    repeat (WD - 1) @(negedge clk);
    chk("R11 before limit err", int'(err), 0);
    chk("R11 before limit valid", int'(req_valid), 1);
    @(negedge clk);
    chk("R11 err", int'(err), 1);
    chk("R11 done", int'(done), 1);
    chk("R11 valid dropped", int'(req_valid), 0);
    chk("R11 count kept", int'(blk_count), 0);

    // R12 restart after abort clears flags and completes
    run_seq(1'b0, 0, SMALL);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule